// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the processor clock, the peripheral clock and the oscillator run. The instruction decoder gives it one-cycle strobes for the two sleep instructions. The block moves between a running state, a light sleep and a deep sleep. It also tells the fetch unit where execution resumes after a wake.

In light sleep, only the processor clock is gated. Timers and interrupt logic keep their clock, so they can still wake the core. An interrupt in light sleep resumes the program at the instruction after the sleep instruction. A watchdog expiry in light sleep restarts the program from the reset vector.

Deep sleep gates both clocks and requests that the oscillator stop. It is reached only when software has cleared an external disable bit; otherwise the deep-sleep instruction does nothing. A wake event from deep sleep restarts the program from the reset vector. The wake also asks for the disable bit to be set again, so that every later deep sleep needs a fresh software opt-in.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `cpu_clk_en`=1, `periph_clk_en`=1, `osc_stop`=0, `resume_next`=0, `load_rst_vec`=1 and `stop_dis_set`=1. On the first clock edge after reset is released, `load_rst_vec` and `stop_dis_set` return to 0.
- R2: A `halt_stb` in the running state, with no enabled deep-sleep request in the same cycle, gives `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_stop`=0 from the next cycle on.
- R3: A `stop_stb` in the running state while `stop_dis`=1, with no `halt_stb`, has no effect: all six outputs keep their running values.
- R4: A `stop_stb` in the running state while `stop_dis`=0 gives `cpu_clk_en`=0, `periph_clk_en`=0 and `osc_stop`=1 from the next cycle on.
- R5: When `halt_stb` and `stop_stb` arrive in the same cycle, the block enters deep sleep if `stop_dis`=0 and light sleep if `stop_dis`=1.
- R6: In light sleep, `irq` without `wdt_timeout` returns the block to running on the next cycle. For exactly that one cycle `resume_next`=1 and `load_rst_vec`=0.
- R7: In light sleep, `wdt_timeout` returns the block to running on the next cycle. For exactly that one cycle `load_rst_vec`=1 and `resume_next`=0. This also holds when `irq` is high in the same cycle.
- R8: In deep sleep, `stop_wake` returns the block to running on the next cycle. For exactly that one cycle both `load_rst_vec`=1 and `stop_dis_set`=1.
- R9: The following inputs leave the outputs unchanged:
  - `irq` and `wdt_timeout` in deep sleep or in the running state;
  - `stop_wake` outside deep sleep;
  - both sleep strobes outside the running state.
- R10: `cpu_clk_en`=1 always implies `periph_clk_en`=1, and `osc_stop`=1 always implies that both clock enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_stb | input | 1 | Light-sleep instruction decoded (one cycle) |
| stop_stb | input | 1 | Deep-sleep instruction decoded (one cycle) |
| irq | input | 1 | Pending interrupt request |
| wdt_timeout | input | 1 | Watchdog expiry |
| stop_wake | input | 1 | Wake event for deep sleep |
| stop_dis | input | 1 | Deep-sleep disable bit (1 = deep sleep acts as no-op) |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Timer and interrupt clock enable |
| osc_stop | output | 1 | Request to halt the oscillator |
| resume_next | output | 1 | Continue after the sleep instruction (one cycle) |
| load_rst_vec | output | 1 | Restart from the reset vector |
| stop_dis_set | output | 1 | Request to set the deep-sleep disable bit |

## Verification
Every result is registered, so each one appears exactly one clock edge after the cycle that holds its stimulus. This applies to the clock enables, the oscillator request and all three one-cycle flags. The only exception is reset, which acts asynchronously; its values are visible in the same cycle and are cleared by the first edge after release.

The bench drives each stimulus at a falling edge and lets one rising edge pass. It then compares all six outputs against a behavioural model at the next falling edge, so every sample falls in the cycle where the response is due. Directed runs cover each entry, wake and ignore case, including same-cycle conflicts and a reset taken during light sleep. A long run with random inputs follows.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_HALT = 2'd1,
      PM_STOP = 2'd2
   } pm_state_e;

   localparam int unsigned PM_NUM_STATES = 3;

   typedef struct packed {
      logic resume;
      logic vec_load;
      logic dis_set;
   } pm_pulse_t;

   localparam pm_pulse_t PM_PULSE_RESET = '{resume: 1'b0, vec_load: 1'b1, dis_set: 1'b1};

endpackage

// File: rtl/pms_next_state.sv
module pms_next_state
   import pms_pkg::*;
#(
   parameter int WDT_OVER_IRQ = 1
) (
   input  pm_state_e cur_st,
   input  logic      halt_stb,
   input  logic      stop_stb,
   input  logic      irq,
   input  logic      wdt_timeout,
   input  logic      stop_wake,
   input  logic      stop_dis,
   output pm_state_e nxt_st,
   output pm_pulse_t pulse_d
);

   logic wdt_hit;
   logic irq_hit;
   logic deep_go;

   if (WDT_OVER_IRQ < 0 || WDT_OVER_IRQ > 1) begin : g_bad_prio
      $error("WDT_OVER_IRQ must be 0 or 1");
   end

   if (WDT_OVER_IRQ == 1) begin : g_wdt_first
      assign wdt_hit = wdt_timeout;
      assign irq_hit = irq & ~wdt_timeout;
   end else begin : g_irq_first
      assign irq_hit = irq;
      assign wdt_hit = wdt_timeout & ~irq;
   end

   assign deep_go = stop_stb & ~stop_dis;

   always_comb begin
      nxt_st  = cur_st;
      pulse_d = '0;
      case (cur_st)
         PM_RUN: begin
            if (deep_go) begin
               nxt_st = PM_STOP;
            end else if (halt_stb) begin
               nxt_st = PM_HALT;
            end
         end
         PM_HALT: begin
            if (wdt_hit) begin
               nxt_st           = PM_RUN;
               pulse_d.vec_load = 1'b1;
            end else if (irq_hit) begin
               nxt_st         = PM_RUN;
               pulse_d.resume = 1'b1;
            end
         end
         PM_STOP: begin
            if (stop_wake) begin
               nxt_st           = PM_RUN;
               pulse_d.vec_load = 1'b1;
               pulse_d.dis_set  = 1'b1;
            end
         end
         default: nxt_st = PM_RUN;
      endcase
   end

endmodule

// File: rtl/pms_state_reg.sv
module pms_state_reg
   import pms_pkg::*;
#(
   parameter int STATE_ENC = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pm_state_e nxt_st,
   output pm_state_e cur_st
);

   localparam int unsigned OH_W = PM_NUM_STATES;

   if (STATE_ENC < 0 || STATE_ENC > 1) begin : g_bad_enc
      $error("STATE_ENC must be 0 (binary) or 1 (one-hot)");
   end

   if (STATE_ENC == 1) begin : g_onehot
      logic [OH_W-1:0] oh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oh_q <= OH_W'(1);
         end else begin
            oh_q <= OH_W'(1) << nxt_st;
         end
      end

      always_comb begin
         if (oh_q[PM_STOP]) begin
            cur_st = PM_STOP;
         end else if (oh_q[PM_HALT]) begin
            cur_st = PM_HALT;
         end else begin
            cur_st = PM_RUN;
         end
      end

      AST_ONEHOT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(oh_q)); // R10
   end else begin : g_binary
      pm_state_e st_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= PM_RUN;
         end else begin
            st_q <= nxt_st;
         end
      end

      assign cur_st = st_q;
   end

endmodule

// File: rtl/pms_clk_ctrl.sv
module pms_clk_ctrl
   import pms_pkg::*;
(
   input  pm_state_e cur_st,
   output logic      cpu_clk_en,
   output logic      periph_clk_en,
   output logic      osc_stop
);

   assign cpu_clk_en    = (cur_st == PM_RUN);
   assign periph_clk_en = (cur_st != PM_STOP);
   assign osc_stop      = (cur_st == PM_STOP);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int STATE_ENC    = 0,
   parameter int WDT_OVER_IRQ = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_stb,
   input  logic stop_stb,
   input  logic irq,
   input  logic wdt_timeout,
   input  logic stop_wake,
   input  logic stop_dis,
   output logic cpu_clk_en,
   output logic periph_clk_en,
   output logic osc_stop,
   output logic resume_next,
   output logic load_rst_vec,
   output logic stop_dis_set
);

   pm_state_e cur_st;
   pm_state_e nxt_st;
   pm_pulse_t pulse_d;
   pm_pulse_t pulse_q;

   pms_next_state #(
      .WDT_OVER_IRQ(WDT_OVER_IRQ)
   ) u_next (
      .cur_st     (cur_st),
      .halt_stb   (halt_stb),
      .stop_stb   (stop_stb),
      .irq        (irq),
      .wdt_timeout(wdt_timeout),
      .stop_wake  (stop_wake),
      .stop_dis   (stop_dis),
      .nxt_st     (nxt_st),
      .pulse_d    (pulse_d)
   );

   pms_state_reg #(
      .STATE_ENC(STATE_ENC)
   ) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt_st(nxt_st),
      .cur_st(cur_st)
   );

   pms_clk_ctrl u_clk (
      .cur_st       (cur_st),
      .cpu_clk_en   (cpu_clk_en),
      .periph_clk_en(periph_clk_en),
      .osc_stop     (osc_stop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= PM_PULSE_RESET;
      end else begin
         pulse_q <= pulse_d;
      end
   end

   assign resume_next  = pulse_q.resume;
   assign load_rst_vec = pulse_q.vec_load;
   assign stop_dis_set = pulse_q.dis_set;

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en && halt_stb && !(stop_stb && !stop_dis) |=> !cpu_clk_en && periph_clk_en && !osc_stop); // R2
   AST_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en && stop_stb && stop_dis && !halt_stb |=> cpu_clk_en && !osc_stop); // R3
   AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en && stop_stb && !stop_dis |=> osc_stop && !periph_clk_en); // R4
   AST_IRQ_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en && periph_clk_en && irq && !wdt_timeout |=> cpu_clk_en && resume_next && !load_rst_vec); // R6
   AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      resume_next |=> !resume_next); // R6
   AST_WDT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en && periph_clk_en && wdt_timeout |=> cpu_clk_en && load_rst_vec && !resume_next); // R7
   AST_STOP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop && stop_wake |=> cpu_clk_en && load_rst_vec && stop_dis_set); // R8
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop && !stop_wake |=> osc_stop && !load_rst_vec); // R9
   AST_CPU_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> periph_clk_en); // R10

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_stb = 1'b0;
   logic stop_stb = 1'b0;
   logic irq = 1'b0;
   logic wdt_timeout = 1'b0;
   logic stop_wake = 1'b0;
   logic stop_dis = 1'b1;
   logic cpu_clk_en, periph_clk_en, osc_stop, resume_next, load_rst_vec, stop_dis_set;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // behavioural reference: 0 = running, 1 = light sleep, 2 = deep sleep
   int m_st;
   bit m_res, m_ld, m_set;

   always #5 clk = ~clk;

   pwr_mode_seq u_pwr_mode_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_stb     (halt_stb),
      .stop_stb     (stop_stb),
      .irq          (irq),
      .wdt_timeout  (wdt_timeout),
      .stop_wake    (stop_wake),
      .stop_dis     (stop_dis),
      .cpu_clk_en   (cpu_clk_en),
      .periph_clk_en(periph_clk_en),
      .osc_stop     (osc_stop),
      .resume_next  (resume_next),
      .load_rst_vec (load_rst_vec),
      .stop_dis_set (stop_dis_set)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 0; m_res <= 1'b0; m_ld <= 1'b1; m_set <= 1'b1;
      end else begin
         m_res <= 1'b0; m_ld <= 1'b0; m_set <= 1'b0;
         if (m_st == 0) begin
            if (stop_stb && !stop_dis) m_st <= 2;
            else if (halt_stb) m_st <= 1;
         end else if (m_st == 1) begin
            if (wdt_timeout) begin m_st <= 0; m_ld <= 1'b1; end
            else if (irq) begin m_st <= 0; m_res <= 1'b1; end
         end else begin
            if (stop_wake) begin m_st <= 0; m_ld <= 1'b1; m_set <= 1'b1; end
         end
      end
   end

   task automatic chk(input string req);
      logic [5:0] act, exp;
      act = {cpu_clk_en, periph_clk_en, osc_stop, resume_next, load_rst_vec, stop_dis_set};
      exp = {m_st == 0, m_st != 2, m_st == 2, m_res, m_ld, m_set};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cpu/per/osc/res/ld/set act=%b exp=%b", req, act, exp);
      end
   endtask

   // drive one cycle of inputs at a falling edge, check the response one edge later
   task automatic cyc(input string req, input logic h, input logic s, input logic i,
                      input logic w, input logic k, input logic d);
      halt_stb = h; stop_stb = s; irq = i; wdt_timeout = w; stop_wake = k; stop_dis = d;
      @(negedge clk);
      chk(req);
      halt_stb = 1'b0; stop_stb = 1'b0; irq = 1'b0; wdt_timeout = 1'b0; stop_wake = 1'b0;
   endtask

   task automatic idle(input string req, input int n);
      for (int j = 0; j < n; j++) cyc(req, 0, 0, 0, 0, 0, stop_dis);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      @(negedge clk); chk("R1");
      @(negedge clk); chk("R1");
      rst_n = 1'b1;
      idle("R1", 2);
      // R2 light sleep entry, R9 ignored inputs while asleep, R6 interrupt resume
      cyc("R2", 1, 0, 0, 0, 0, 1);
      idle("R2", 2);
      cyc("R9", 0, 0, 0, 0, 1, 1);
      cyc("R9", 1, 1, 0, 0, 0, 0);
      cyc("R6", 0, 0, 1, 0, 0, 1);
      idle("R6", 2);
      // R3 deep sleep disabled acts as no-op
      cyc("R3", 0, 1, 0, 0, 0, 1);
      idle("R3", 2);
      // R4 deep sleep entry, R9 ignored inputs, R8 wake
      cyc("R4", 0, 1, 0, 0, 0, 0);
      idle("R4", 2);
      cyc("R9", 0, 0, 1, 0, 0, 0);
      cyc("R9", 0, 0, 0, 1, 0, 0);
      cyc("R9", 1, 1, 0, 0, 0, 0);
      cyc("R8", 0, 0, 0, 0, 1, 0);
      idle("R8", 2);
      // R5 same-cycle conflict
      cyc("R5", 1, 1, 0, 0, 0, 0);
      idle("R5", 1);
      cyc("R8", 0, 0, 0, 0, 1, 0);
      cyc("R5", 1, 1, 0, 0, 0, 1);
      idle("R5", 1);
      // R7 watchdog beats interrupt
      cyc("R7", 0, 0, 1, 1, 0, 1);
      idle("R7", 1);
      cyc("R7", 1, 0, 0, 0, 0, 1);
      cyc("R7", 0, 0, 0, 1, 0, 1);
      idle("R7", 2);
      // R9 running-state ignores
      cyc("R9", 0, 0, 1, 0, 0, 1);
      cyc("R9", 0, 0, 0, 1, 0, 1);
      cyc("R9", 0, 0, 0, 0, 1, 0);
      // R1 reset taken during light sleep
      cyc("R1", 1, 0, 0, 0, 0, 1);
      rst_n = 1'b0;
      @(negedge clk); chk("R1");
      rst_n = 1'b1;
      idle("R1", 2);
      // R10 random traffic
      for (int n = 0; n < 3000; n++) begin
         cyc("R10", ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
             ($urandom % 7) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0);
      end
      summary();
   end

endmodule